// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single bus cycles on a 16-bit bus whose address and data share one set of pins. A requester presents a read or a write with a 20-bit address, which spans a 1 MB space, and write data. The sequencer then steps through four fixed clock phases, named T1 to T4. In T1 it puts the address on the shared lines and raises the address latch enable. An external latch holds the address once that enable goes low. In T2 to T4 the same lines carry data through an external transceiver, which the block enables.

A read releases the shared lines from T2 onward and asserts the read strobe. The external memory then drives the data. The block samples that data at the end of T3 and returns it with a one-cycle done pulse in T4. A write keeps the shared lines driven with the write data and asserts the write strobe. The pad ring resolves the shared pins. The block sees them as a driven value, an output enable and a sampled input.

A request is taken only while the block is idle or in T4, so cycles can follow each other without a gap. The upper four address bits have their own pins and are driven during T1 only.

Top module: `mbus_sequencer`

## Requirements
- R1: An accepted request produces exactly four cycles, T1, T2, T3, T4, in that order. The first of them is the cycle right after the acceptance edge.
- R2: During T1, `ale` is 1 and `ad_oe` is 1. `ad_out` carries address bits [15:0] and `addr_hi` carries address bits [19:16]. `ale` is 0 in every other cycle.
- R3: During T2, T3 and T4, `xcvr_en` is 1. Outside these phases it is 0.
- R4: In a write, `ad_oe` is 1 and `ad_out` holds the write data from T2 to T4. `wr_strobe` is 1 in T2 and T3, and `rd_strobe` stays 0.
- R5: In a read, `ad_oe` is 0 from T2 to T4. `rd_strobe` is 1 in T2 and T3, and `wr_strobe` stays 0.
- R6: A read captures `ad_in` at the clock edge that ends T3 and presents it on `rsp_rdata` while `rsp_done` is 1. `rsp_done` is 1 for one cycle, in T4, for both reads and writes.
- R7: `req_ready` is 1 only when the block is idle or in T4. A `req_valid` raised in T1, T2 or T3 is ignored: it starts no cycle and does not change the cycle in progress.
- R8: A request held valid in T4 starts T1 in the very next cycle. Without a request, T4 is followed by idle.
- R9: After reset, and while idle, `ale`, `ad_oe`, `rd_strobe`, `wr_strobe`, `xcvr_en` and `rsp_done` are all 0, and `req_ready` is 1.
- R10: All 20 address bits reach the external latch unchanged. This includes the extremes 0x00000 and 0xFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request taken at this edge if valid |
| ad_out | output | 16 | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 16 | Value sampled from the shared lines |
| addr_hi | output | 4 | Upper address bits, valid in T1 |
| ale | output | 1 | Address latch enable, high in T1 |
| rd_strobe | output | 1 | Read command |
| wr_strobe | output | 1 | Write command |
| xcvr_en | output | 1 | Data transceiver enable |
| rsp_done | output | 1 | One-cycle completion pulse in T4 |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |

## Verification
A phase register that skips or repeats a state shows up at the pins within one cycle. It gives an `ale` pulse wider than one cycle, a strobe that lasts one or three cycles, or a done pulse that arrives early, late or twice. A stale request register shows up at the next T1 as the wrong address in the external latch. It also shows up at T2 as the wrong write data. A wrong read-capture enable shows up in T4 as the wrong value on `rsp_rdata`. An acceptance window that is open too wide shows up one cycle after a stray request: a second `ale` pulse, or a cycle that does not return to idle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } bus_phase_e;

  function automatic logic in_data_phase(input bus_phase_e p);
    return (p == ST_T2) || (p == ST_T3) || (p == ST_T4);
  endfunction

  function automatic logic in_strobe_phase(input bus_phase_e p);
    return (p == ST_T2) || (p == ST_T3);
  endfunction
endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output bus_phase_e phase,
  output logic       req_ready,
  output logic       accept
);
  bus_phase_e phase_q, phase_d;

  assign req_ready = (phase_q == ST_IDLE) || (phase_q == ST_T4);
  assign accept    = req_ready && req_valid;
  assign phase     = phase_q;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      ST_IDLE: if (accept) phase_d = ST_T1;
      ST_T1:   phase_d = ST_T2;
      ST_T2:   phase_d = ST_T3;
      ST_T3:   phase_d = ST_T4;
      ST_T4:   phase_d = accept ? ST_T1 : ST_IDLE;
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= ST_IDLE;
    else        phase_q <= phase_d;
  end

  assert_t1_to_t2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == ST_T1 |=> phase_q == ST_T2);
  assert_t2_to_t3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == ST_T2 |=> phase_q == ST_T3);
  assert_t3_to_t4_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == ST_T3 |=> phase_q == ST_T4);
  assert_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_T4 && req_valid) |=> phase_q == ST_T1);
  assert_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_T4 && !req_valid) |=> phase_q == ST_IDLE);
  assert_no_mid_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_T2 || phase_q == ST_T3) |=> phase_q != ST_T1);
endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_phase_e        phase,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic              ale,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              xcvr_en,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              data_ph;
  logic              strobe_ph;
  logic              rd_capture;

  // request capture, enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // read data capture on the edge leaving T3
  assign rd_capture = (phase == ST_T3) && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (rd_capture) rdata_q <= ad_in;
  end

  always_comb begin
    data_ph   = in_data_phase(phase);
    strobe_ph = in_strobe_phase(phase);
    ale       = (phase == ST_T1);
    xcvr_en   = data_ph;
    rd_strobe = strobe_ph && !wr_q;
    wr_strobe = strobe_ph && wr_q;
    rsp_done  = (phase == ST_T4);
    ad_oe     = ale || (data_ph && wr_q);
    ad_out    = '0;
    addr_hi   = '0;
    if (ale) begin
      ad_out  = addr_q[DATA_W-1:0];
      addr_hi = addr_q[ADDR_W-1:DATA_W];
    end else if (data_ph && wr_q) begin
      ad_out  = wdata_q;
    end
  end

  assign rsp_rdata = rdata_q;

  assert_ale_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && xcvr_en));
  assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> !ad_oe);
  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));
  assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && $past(wr_strobe)) |-> $stable(ad_out));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  assert_hi_only_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |-> (addr_hi == {HI_W{1'b0}}));
endmodule

// File: rtl/mbus_sequencer.sv
module mbus_sequencer
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     rd_strobe,
  output logic                     wr_strobe,
  output logic                     xcvr_en,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata
);
  bus_phase_e phase;
  logic       accept;

  mbus_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .phase     (phase),
    .req_ready (req_ready),
    .accept    (accept)
  );

  mbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .addr_hi   (addr_hi),
    .ale       (ale),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .xcvr_en   (xcvr_en),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: tb/mbus_sequencer_bench.sv
module mbus_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in;
  logic [3:0]  addr_hi;
  logic        ale;
  logic        rd_strobe;
  logic        wr_strobe;
  logic        xcvr_en;
  logic        rsp_done;
  logic [15:0] rsp_rdata;

  int n_chk;
  int n_bad;

  mbus_sequencer u_mbus_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi),
    .ale(ale), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .xcvr_en(xcvr_en), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // external address latch and memory model
  logic [19:0] shadow_addr;
  logic [19:0] lat_addr;
  logic [19:0] wr_seen_addr;
  logic [15:0] wr_seen_data;

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], a[19:16], 8'h3C};
  endfunction

  always @(negedge clk) if (ale) shadow_addr <= {addr_hi, ad_out};
  always @(negedge ale) lat_addr <= shadow_addr;
  always @(negedge clk) if (wr_strobe) begin
    wr_seen_addr <= lat_addr;
    wr_seen_data <= ad_out;
  end
  assign ad_in = rd_strobe ? mem_word(lat_addr) : 16'hFFFF;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic set_req(input logic v, input logic wr, input logic [19:0] a, input logic [15:0] d);
    req_valid = v;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
  endtask

  // Runs T1..T4 of a cycle whose request is already presented.
  task automatic run_cycle(input logic wr, input logic [19:0] a, input logic [15:0] d,
                           input logic chain, input logic cwr, input logic [19:0] ca,
                           input logic [15:0] cd, input logic poke);
    step; // T1
    check("R2 ale in T1", ale, 1);
    check("R2 oe in T1", ad_oe, 1);
    check("R2 low addr", ad_out, a[15:0]);
    check("R2 high addr", addr_hi, a[19:16]);
    check("R3 xcvr off in T1", xcvr_en, 0);
    check("R7 not ready in T1", req_ready, 0);
    if (poke) set_req(1, !wr, 20'h0BEEF, 16'hBAD0);
    else set_req(0, 0, 20'h0, 16'h0);
    step; // T2
    set_req(0, 0, 20'h0, 16'h0);
    check("R2 ale low in T2", ale, 0);
    check("R3 xcvr in T2", xcvr_en, 1);
    check("R10 latched address", lat_addr, a);
    if (wr) begin
      check("R4 oe in T2", ad_oe, 1);
      check("R4 wdata in T2", ad_out, d);
      check("R4 wr strobe T2", wr_strobe, 1);
      check("R4 no rd strobe", rd_strobe, 0);
    end else begin
      check("R5 released in T2", ad_oe, 0);
      check("R5 rd strobe T2", rd_strobe, 1);
      check("R5 no wr strobe", wr_strobe, 0);
    end
    step; // T3
    check("R1 T3 not done", rsp_done, 0);
    check("R3 xcvr in T3", xcvr_en, 1);
    if (wr) begin
      check("R4 wr strobe T3", wr_strobe, 1);
      check("R4 memory saw addr", wr_seen_addr, a);
      check("R4 memory saw data", wr_seen_data, d);
    end else begin
      check("R5 rd strobe T3", rd_strobe, 1);
      check("R5 released in T3", ad_oe, 0);
    end
    step; // T4
    check("R6 done in T4", rsp_done, 1);
    check("R3 xcvr in T4", xcvr_en, 1);
    check("R7 ready in T4", req_ready, 1);
    check("R4 R5 strobes off in T4", {rd_strobe, wr_strobe}, 0);
    if (wr) begin
      check("R4 oe in T4", ad_oe, 1);
      check("R4 wdata in T4", ad_out, d);
    end else begin
      check("R6 read data", rsp_rdata, mem_word(a));
      check("R5 released in T4", ad_oe, 0);
    end
    if (chain) set_req(1, cwr, ca, cd);
  endtask

  task automatic check_idle(input string tag);
    step;
    check({"R8 R9 idle ale ", tag}, ale, 0);
    check({"R9 idle done ", tag}, rsp_done, 0);
    check({"R9 idle oe ", tag}, ad_oe, 0);
    check({"R9 idle xcvr ", tag}, xcvr_en, 0);
    check({"R7 idle ready ", tag}, req_ready, 1);
  endtask

  task automatic t_reset;
    set_req(0, 0, 20'h0, 16'h0);
    rst_n = 1'b0;
    repeat (3) step;
    rst_n = 1'b1;
    step;
    check("R9 ale", ale, 0);
    check("R9 oe", ad_oe, 0);
    check("R9 strobes", {rd_strobe, wr_strobe, xcvr_en}, 0);
    check("R9 done", rsp_done, 0);
    check("R9 ready", req_ready, 1);
  endtask

  task automatic t_read(input logic [19:0] a);
    set_req(1, 0, a, 16'h0);
    run_cycle(0, a, 16'h0, 0, 0, 20'h0, 16'h0, 0);
    check_idle("after read");
  endtask

  task automatic t_write(input logic [19:0] a, input logic [15:0] d);
    set_req(1, 1, a, d);
    run_cycle(1, a, d, 0, 0, 20'h0, 16'h0, 0);
    check_idle("after write");
  endtask

  task automatic t_back_to_back;
    set_req(1, 0, 20'h54321, 16'h0);
    run_cycle(0, 20'h54321, 16'h0, 1, 1, 20'h9F00F, 16'h1234, 0);
    run_cycle(1, 20'h9F00F, 16'h1234, 1, 0, 20'h80001, 16'h0, 0);
    run_cycle(0, 20'h80001, 16'h0, 0, 0, 20'h0, 16'h0, 0);
    check_idle("R8 after chain");
  endtask

  task automatic t_ignored_request;
    set_req(1, 0, 20'h33333, 16'h0);
    run_cycle(0, 20'h33333, 16'h0, 0, 0, 20'h0, 16'h0, 1);
    check_idle("R7 stray request");
    step;
    check("R7 no late cycle", ale, 0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset;
    t_read(20'h12345);
    t_write(20'hFFFFF, 16'hA55A);
    t_read(20'h00000);
    t_read(20'hFFFFF);
    t_write(20'hABCDE, 16'h0F0F);
    t_back_to_back;
    t_ignored_request;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule